// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between a set of free-running source clocks and the clock pins of a system clock generator. It controls five clock groups: a CPU group that fans out to `CPU_N` identical outputs, a single PCI reference output, `REF_N` reference outputs with their own sources, and an auxiliary pair (a main auxiliary clock and its half-rate companion). Four active-low requests come from outside and may change at any time: stop the CPU group, stop the PCI output, power the whole part down, and power down the auxiliary PLL. Each request passes through a two-flop synchronizer before it acts.

Each output has its own gate. The gate's enable changes only while that output's source is low. A stopped output therefore parks at logic 0, and a restarted output begins with a complete high phase. A full power-down first gates every output low. Only then does it drop the VCO enable, and one cycle after that the crystal oscillator enable. On release the crystal comes back first and the VCO one cycle later. A programmable settle interval then runs before any output is ungated.

The source clocks are modelled as levels sampled on the controller clock `clk`, which must run faster than every source. The PLLs, the oscillators and spread spectrum lie outside the block.

Top module: `clkpd_top`

## Requirements
- R1: While reset is held, every clock output is 0, `vcoEn` and `xtalEn` are 1, `pdDone` is 0 and every stopped flag is 1.
- R2: While `stopCpuN` is low (after synchronization) and power-down is inactive, all `CPU_N` bits of `cpuClk` are 0. Every other output keeps following its source.
- R3: While `stopPciN` is low and power-down is inactive, `pciClk` is 0 and every other output keeps following its source.
- R4: No runt pulses. An output rises only in a cycle where its source rises, and falls only in a cycle where its source falls, so every high phase it drives has full width.
- R5: With `pwrDnN` high and `auxPdN` low, only `auxClk` and `auxDiv2Clk` are held at 0. CPU, PCI and REF outputs continue.
- R6: A running output follows its source exactly. The output equals the source while the group is enabled.
- R7: While `pwrDnN` is low, once the power-down sequence has finished (`pdDone` = 1), every clock output stays at 0.
- R8: On power-down, `vcoEn` goes low only after all four stopped flags are 1. `xtalEn` goes low in a later cycle than `vcoEn`.
- R9: On wake-up, `xtalEn` rises exactly one cycle before `vcoEn`. The CPU output stays low for at least `SETTLE_CYC` cycles after `vcoEn` rises, and at most `SETTLE_CYC`+3 cycles.
- R10: The stopped flags are 1 exactly when their group is held: `cpuStopped`, `pciStopped`, all REF lanes for `refStopped`, both auxiliary lanes for `auxStopped`. Once a lane is commanded off and its source is low, the lane is stopped in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, faster than every source |
| rstN | input | 1 | Active-low reset |
| stopCpuN | input | 1 | Async request, low stops the CPU group |
| stopPciN | input | 1 | Async request, low stops the PCI output |
| pwrDnN | input | 1 | Async request, low powers the part down |
| auxPdN | input | 1 | Async request, low stops the auxiliary pair |
| cpuSrc | input | 1 | Free-running CPU source level |
| pciSrc | input | 1 | Free-running PCI source level |
| refSrc | input | REF_N | Free-running REF source levels |
| auxSrc | input | 1 | Auxiliary source level |
| auxDiv2Src | input | 1 | Half-rate auxiliary source level |
| cpuClk | output | CPU_N | Gated CPU clocks |
| pciClk | output | 1 | Gated PCI reference clock |
| refClk | output | REF_N | Gated REF clocks |
| auxClk | output | 1 | Gated auxiliary clock |
| auxDiv2Clk | output | 1 | Gated half-rate auxiliary clock |
| vcoEn | output | 1 | VCO enable |
| xtalEn | output | 1 | Crystal oscillator enable |
| cpuStopped | output | 1 | CPU group held low |
| pciStopped | output | 1 | PCI output held low |
| refStopped | output | 1 | All REF outputs held low |
| auxStopped | output | 1 | Both auxiliary outputs held low |
| pdDone | output | 1 | Power-down sequence finished |

## Verification
The assertions assume the following:
- Every source level changes at most once per `clk` period.
- Each source is low for at least one `clk` sample in every period, so every gate eventually gets a window in which it may switch.
- Sources and request levels are defined from time zero.

The bench meets these conditions by driving all sources on the falling edge of `clk` from one phase counter. Each source uses a period of two to sixteen cycles and a high time of at least one cycle. Requests change only on falling edges and are held for tens of cycles, which is longer than the synchronizer and the slowest source period combined.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;

  typedef struct packed {
    logic cpuRun;
    logic pciRun;
    logic refRun;
    logic auxRun;
  } gateCmd_t;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_VCO_OFF = 3'd2,
    ST_DOWN    = 3'd3,
    ST_XTAL_ON = 3'd4,
    ST_SETTLE  = 3'd5
  } pdState_t;

endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  // Reset value is all ones: every active-low request reads as inactive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
  import clkpd_pkg::*;
#(
  parameter int SETTLE_CYC = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     stopCpuReq,
  input  logic     stopPciReq,
  input  logic     pdReq,
  input  logic     auxPdReq,
  input  logic     allStopped,
  output gateCmd_t cmd,
  output logic     vcoEn,
  output logic     xtalEn,
  output logic     pdDone
);

  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);

  pdState_t state, stateNxt;
  logic [CW-1:0] settleCnt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_RUN:     if (pdReq) stateNxt = ST_DRAIN;
      ST_DRAIN:   if (allStopped) stateNxt = ST_VCO_OFF;
      ST_VCO_OFF: stateNxt = ST_DOWN;
      ST_DOWN:    if (!pdReq) stateNxt = ST_XTAL_ON;
      ST_XTAL_ON: stateNxt = ST_SETTLE;
      ST_SETTLE:  if (settleCnt == SETTLE_LAST) stateNxt = ST_RUN;
      default:    stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      settleCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
    end
  end

  logic running;
  assign running    = (state == ST_RUN);
  assign cmd.cpuRun = running & ~stopCpuReq;
  assign cmd.pciRun = running & ~stopPciReq;
  assign cmd.refRun = running;
  assign cmd.auxRun = running & ~auxPdReq;

  assign vcoEn  = (state == ST_RUN) || (state == ST_DRAIN) || (state == ST_SETTLE);
  assign xtalEn = (state != ST_DOWN);
  assign pdDone = (state == ST_DOWN);

  // R8
  vco_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vcoEn |-> allStopped);

  // R8
  xtal_after_vco_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xtalEn) |-> $past(!vcoEn));

  // R9
  vco_after_xtal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vcoEn) |-> (xtalEn && $past(xtalEn)));

  // R7
  down_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    pdDone |-> allStopped);

endmodule

// File: rtl/clkpd_gates.sv
module clkpd_gates
  import clkpd_pkg::*;
#(
  parameter int REF_N = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateCmd_t         cmd,
  input  logic [LANES-1:0] laneSrc,
  output logic [LANES-1:0] laneOut,
  output logic [LANES-1:0] laneEn
);

  localparam int LANES   = REF_N + 4;
  localparam int REF_LO  = 2;
  localparam int AUX_IDX = REF_N + 2;
  localparam int AUXD_IDX = REF_N + 3;

  logic [LANES-1:0] laneWant;

  always_comb begin
    laneWant = '0;
    laneWant[0] = cmd.cpuRun;
    laneWant[1] = cmd.pciRun;
    for (int r = 0; r < REF_N; r++) laneWant[REF_LO + r] = cmd.refRun;
    laneWant[AUX_IDX]  = cmd.auxRun;
    laneWant[AUXD_IDX] = cmd.auxRun;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // The enable may switch only while the source is low.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            laneEn[g] <= 1'b0;
      else if (!laneSrc[g]) laneEn[g] <= laneWant[g];
    end

    assign laneOut[g] = laneSrc[g] & laneEn[g];

    // R4
    lane_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(laneOut[g]) |-> $rose(laneSrc[g]));

    // R4
    lane_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(laneOut[g]) |-> $fell(laneSrc[g]));

    // R10
    lane_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!laneWant[g] && !laneSrc[g]) |=> !laneEn[g]);
  end

endmodule

// File: rtl/clkpd_top.sv
module clkpd_top
  import clkpd_pkg::*;
#(
  parameter int CPU_N      = 12,
  parameter int REF_N      = 2,
  parameter int SETTLE_CYC = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopCpuN,
  input  logic             stopPciN,
  input  logic             pwrDnN,
  input  logic             auxPdN,
  input  logic             cpuSrc,
  input  logic             pciSrc,
  input  logic [REF_N-1:0] refSrc,
  input  logic             auxSrc,
  input  logic             auxDiv2Src,
  output logic [CPU_N-1:0] cpuClk,
  output logic             pciClk,
  output logic [REF_N-1:0] refClk,
  output logic             auxClk,
  output logic             auxDiv2Clk,
  output logic             vcoEn,
  output logic             xtalEn,
  output logic             cpuStopped,
  output logic             pciStopped,
  output logic             refStopped,
  output logic             auxStopped,
  output logic             pdDone
);

  localparam int LANES = REF_N + 4;

  logic [3:0]       reqSync;
  gateCmd_t         cmd;
  logic [LANES-1:0] laneSrc, laneOut, laneEn;
  logic             allStopped;

  clkpd_sync #(.WIDTH(4)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({auxPdN, pwrDnN, stopPciN, stopCpuN}),
    .syncOut(reqSync)
  );

  assign laneSrc = {auxDiv2Src, auxSrc, refSrc, pciSrc, cpuSrc};

  clkpd_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stopCpuReq(~reqSync[0]),
    .stopPciReq(~reqSync[1]),
    .pdReq     (~reqSync[2]),
    .auxPdReq  (~reqSync[3]),
    .allStopped(allStopped),
    .cmd       (cmd),
    .vcoEn     (vcoEn),
    .xtalEn    (xtalEn),
    .pdDone    (pdDone)
  );

  clkpd_gates #(.REF_N(REF_N)) u_gates (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .laneSrc(laneSrc),
    .laneOut(laneOut),
    .laneEn (laneEn)
  );

  assign cpuClk     = {CPU_N{laneOut[0]}};
  assign pciClk     = laneOut[1];
  assign refClk     = laneOut[REF_N+1:2];
  assign auxClk     = laneOut[REF_N+2];
  assign auxDiv2Clk = laneOut[REF_N+3];

  assign cpuStopped = ~laneEn[0];
  assign pciStopped = ~laneEn[1];
  assign refStopped = ~|laneEn[REF_N+1:2];
  assign auxStopped = ~laneEn[REF_N+2] & ~laneEn[REF_N+3];
  assign allStopped = cpuStopped & pciStopped & refStopped & auxStopped;

endmodule

// File: tb/clkpd_top_tb.sv
module clkpd_top_tb;

  localparam int CPU_N  = 12;
  localparam int REF_N  = 2;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopCpuN = 1'b1, stopPciN = 1'b1, pwrDnN = 1'b1, auxPdN = 1'b1;
  logic cpuSrc = 1'b0, pciSrc = 1'b0, auxSrc = 1'b0, auxDiv2Src = 1'b0;
  logic [REF_N-1:0] refSrc = '0;
  logic [CPU_N-1:0] cpuClk;
  logic pciClk, auxClk, auxDiv2Clk, vcoEn, xtalEn;
  logic cpuStopped, pciStopped, refStopped, auxStopped, pdDone;
  logic [REF_N-1:0] refClk;

  int nRun = 0, nFail = 0, runtErr = 0;
  bit monOn = 0;
  int unsigned ph = 0;

  always #5 clk = ~clk;

  clkpd_top #(.CPU_N(CPU_N), .REF_N(REF_N), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .stopCpuN(stopCpuN), .stopPciN(stopPciN),
    .pwrDnN(pwrDnN), .auxPdN(auxPdN), .cpuSrc(cpuSrc), .pciSrc(pciSrc),
    .refSrc(refSrc), .auxSrc(auxSrc), .auxDiv2Src(auxDiv2Src),
    .cpuClk(cpuClk), .pciClk(pciClk), .refClk(refClk), .auxClk(auxClk),
    .auxDiv2Clk(auxDiv2Clk), .vcoEn(vcoEn), .xtalEn(xtalEn),
    .cpuStopped(cpuStopped), .pciStopped(pciStopped), .refStopped(refStopped),
    .auxStopped(auxStopped), .pdDone(pdDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Source generator: periods 2 (cpu), 4 (pci), 6 (ref, offset per lane), 8, 16.
  initial forever begin
    @(negedge clk);
    ph++;
    cpuSrc     = ph[0];
    pciSrc     = ph[1];
    auxSrc     = ph[2];
    auxDiv2Src = ph[3];
    for (int r = 0; r < REF_N; r++) refSrc[r] = (((ph + r) % 6) < 3);
  end

  // Runt monitor for R4: an output edge must coincide with the same source edge.
  logic [REF_N+3:0] pOut = '0, pSrc = '0;
  initial forever begin
    logic [REF_N+3:0] cOut, cSrc;
    @(negedge clk); #1;
    cOut = {auxDiv2Clk, auxClk, refClk, pciClk, cpuClk[0]};
    cSrc = {auxDiv2Src, auxSrc, refSrc, pciSrc, cpuSrc};
    if (monOn) begin
      for (int i = 0; i < REF_N + 4; i++) begin
        if (!pOut[i] && cOut[i] && !(!pSrc[i] && cSrc[i])) runtErr++;
        if (pOut[i] && !cOut[i] && !(pSrc[i] && !cSrc[i])) runtErr++;
      end
    end
    pOut = cOut;
    pSrc = cSrc;
  end

  initial begin
    #(150000 * 10);
    nFail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  initial begin
    int eCpu, ePci, eRef, eAux;
    int vf, xf, ordErr, xi, vi, ci, cyc;
    // R1: reset state
    waitCyc(3);
    chk({cpuClk, pciClk, refClk, auxClk, auxDiv2Clk} == '0, "R1 outputs", int'(cpuClk), 0);
    chk(vcoEn && xtalEn && !pdDone, "R1 osc enables", {vcoEn, xtalEn, pdDone}, 3'b110);
    chk(cpuStopped && pciStopped && refStopped && auxStopped, "R1 stopped flags",
        {cpuStopped, pciStopped, refStopped, auxStopped}, 4'hf);
    rstN = 1'b1;
    waitCyc(30);
    monOn = 1;

    // Sweep all combinations of stop-CPU, stop-PCI, aux power-down.
    for (int c = 0; c < 8; c++) begin
      stopCpuN = ~c[0];
      stopPciN = ~c[1];
      auxPdN   = ~c[2];
      waitCyc(30);
      eCpu = 0; ePci = 0; eRef = 0; eAux = 0;
      for (int k = 0; k < 16; k++) begin
        if (cpuClk !== {CPU_N{cpuSrc & ~c[0]}}) eCpu++;
        if (pciClk !== (pciSrc & ~c[1])) ePci++;
        if (refClk !== refSrc) eRef++;
        if ({auxDiv2Clk, auxClk} !== ({auxDiv2Src, auxSrc} & {2{~c[2]}})) eAux++;
        if ({cpuStopped, pciStopped, refStopped, auxStopped} !== {c[0], c[1], 1'b0, c[2]}) eRef++;
        waitCyc(1);
      end
      chk(eCpu == 0, c[0] ? "R2 cpu held low" : "R6 cpu follows", eCpu, 0);
      chk(ePci == 0, c[1] ? "R3 pci held low" : "R6 pci follows", ePci, 0);
      chk(eRef == 0, "R10 ref runs and flags match", eRef, 0);
      chk(eAux == 0, c[2] ? "R5 aux pair held low" : "R6 aux follows", eAux, 0);
    end
    stopCpuN = 1; stopPciN = 1; auxPdN = 1;
    waitCyc(30);

    // Full power-down.
    pwrDnN = 1'b0;
    vf = -1; xf = -1; ordErr = 0; cyc = 0;
    while (!pdDone && cyc < 200) begin
      if (!vcoEn && !(cpuStopped && pciStopped && refStopped && auxStopped)) ordErr++;
      if (!vcoEn && vf < 0) vf = cyc;
      if (!xtalEn && xf < 0) xf = cyc;
      waitCyc(1);
      cyc++;
    end
    if (!xtalEn && xf < 0) xf = cyc;
    chk(pdDone == 1'b1, "R7 sequence completes", pdDone, 1);
    chk(ordErr == 0, "R8 vco off after all stopped", ordErr, 0);
    chk(vf >= 0 && xf > vf, "R8 xtal off after vco", xf, vf + 1);
    eCpu = 0;
    for (int k = 0; k < 20; k++) begin
      if ({cpuClk, pciClk, refClk, auxClk, auxDiv2Clk} != '0) eCpu++;
      waitCyc(1);
    end
    chk(eCpu == 0, "R7 all outputs held low", eCpu, 0);

    // Wake-up.
    pwrDnN = 1'b1;
    xi = -1; vi = -1; ci = -1; cyc = 0;
    while (ci < 0 && cyc < 300) begin
      if (xtalEn && xi < 0) xi = cyc;
      if (vcoEn && vi < 0) vi = cyc;
      if (cpuClk[0] && ci < 0) ci = cyc;
      waitCyc(1);
      cyc++;
    end
    chk(vi == xi + 1, "R9 xtal one cycle before vco", vi - xi, 1);
    chk(ci - vi >= SETTLE && ci - vi <= SETTLE + 3, "R9 settle interval", ci - vi, SETTLE);
    chk(!pdDone, "R9 pdDone cleared", pdDone, 0);
    waitCyc(20);
    eRef = 0;
    for (int k = 0; k < 16; k++) begin
      if ({refClk, pciClk, auxClk} !== {refSrc, pciSrc, auxSrc}) eRef++;
      waitCyc(1);
    end
    chk(eRef == 0, "R6 all groups resume", eRef, 0);
    chk(runtErr == 0, "R4 no runt edges", runtErr, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule